// File: doc/BRIEF.md
# Framed four-bit pattern detector

This block watches a serial bit stream and cuts it into back-to-back, non-overlapping frames of four bits, counting only the cycles in which the input-valid qualifier is high. On the last bit of each frame it raises a one-cycle detect pulse when the whole frame matches one of two accepted patterns. Whatever the frame held, the machine is back at its start state once the fourth bit is taken, so the next valid bit always opens a new frame.

The detect output is Mealy style: it is formed in the same cycle as the fourth bit is presented. A registered copy, one cycle late and free of combinational hazards, is provided next to it for downstream logic that wants a clean flop output. Frame alignment is set only by reset.

The control is a seven-state machine. Prefixes that can still complete a match have their own states. Prefixes that can no longer match fall into two shared count-out states, one after two bits and one after three bits.

Top module: `quad_frame_detector`

## Requirements
- R1: Valid bits are grouped into consecutive frames of exactly four. After the fourth valid bit of any frame, matching or not, the next valid bit is treated as the first bit of a new frame.
- R2: `hit` is 1 only when the four valid bits of a frame, written first-arriving bit leftmost, read 0101 or 1001. Every other frame value gives no pulse.
- R3: `hit` is combinational. It is high during the cycle that presents the fourth valid bit of a matching frame, and it is 0 while the first three bits of any frame are presented.
- R4: The stream 0101 0010 1001 0100 gives `hit` values 0001 0000 0001 0000 on its valid bits.
- R5: A frame that opens with 00 or 11 cannot produce a pulse in its remaining two bits. The frame after it is aligned and detected normally.
- R6: While `bit_vld` is 0, the bit is neither counted nor matched, the machine state holds, and `hit` is 0.
- R7: `hit_q` equals the value `hit` had in the previous cycle.
- R8: While `rst` is high (synchronous, active high), `hit` is 0. After the reset edge, `hit_q` is 0 and the next valid bit is the first bit of a frame, even if reset arrives in a cycle that presents a matching fourth bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| bit_vld | input | 1 | Qualifier: bit_in is taken only when high |
| hit | output | 1 | Mealy detect pulse on the fourth bit of a matching frame |
| hit_q | output | 1 | hit delayed by one clock through a flop |

## Verification
Two things can land on the same clock as a matching fourth bit: a synchronous reset, or a dropped qualifier. The bench steers the machine into the three-bit prefix state 010. It then presents a 1 with reset high, and separately presents a 1 with `bit_vld` low. In both cases `hit` must stay 0. After the reset case, a fresh frame 1001 must still be detected on its own fourth bit; after the qualifier case, the next valid 1 must complete the match. The stream table and an exhaustive sweep of all sixteen frame values judge the pulse position and the one-cycle lag of `hit_q` on every cycle.

// File: rtl/qfd_pkg.sv
package qfd_pkg;

  // Machine states. Prefix states hold inputs that can still match.
  // SKIP states only count out the rest of a frame that cannot match.
  typedef enum logic [2:0] {
    ST_START = 3'd0,  // no bits of the frame taken
    ST_LEAD0 = 3'd1,  // frame opened with 0
    ST_LEAD1 = 3'd2,  // frame opened with 1
    ST_MID   = 3'd3,  // 01 or 10 taken, 01 still needed
    ST_LAST  = 3'd4,  // 010 or 100 taken, a final 1 matches
    ST_SKIP2 = 3'd5,  // two bits taken, match impossible
    ST_SKIP3 = 3'd6   // three bits taken, match impossible
  } qfd_state_e;

endpackage

// File: rtl/qfd_next.sv
module qfd_next
  import qfd_pkg::*;
(
  input  qfd_state_e cur_st,
  input  logic       bit_in,
  input  logic       bit_vld,
  output qfd_state_e nxt_st,
  output logic       hit_raw
);

  always_comb begin
    nxt_st  = cur_st;
    hit_raw = 1'b0;
    if (bit_vld) begin
      unique case (cur_st)
        ST_START: nxt_st = bit_in ? ST_LEAD1 : ST_LEAD0;
        ST_LEAD0: nxt_st = bit_in ? ST_MID   : ST_SKIP2;
        ST_LEAD1: nxt_st = bit_in ? ST_SKIP2 : ST_MID;
        ST_MID:   nxt_st = bit_in ? ST_SKIP3 : ST_LAST;
        ST_LAST: begin
          nxt_st  = ST_START;
          hit_raw = bit_in;
        end
        ST_SKIP2: nxt_st = ST_SKIP3;
        ST_SKIP3: nxt_st = ST_START;
        default:  nxt_st = ST_START;
      endcase
    end
  end

  // A pulse can only come from the three-bit matching prefix.
  always_comb begin
    AST_HIT_FROM_LAST: assert (!hit_raw || (cur_st == ST_LAST && bit_vld)); // R2
  end

endmodule

// File: rtl/qfd_state_reg.sv
module qfd_state_reg
  import qfd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  qfd_state_e nxt_st,
  input  logic       hit_raw,
  output qfd_state_e st_q,
  output logic       hit_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q  <= ST_START;
      hit_q <= 1'b0;
    end else begin
      st_q  <= nxt_st;
      hit_q <= hit_raw;
    end
  end

  AST_RESET_START: assert property (@(posedge clk)
    rst |=> (st_q == ST_START && !hit_q)); // R8

endmodule

// File: rtl/quad_frame_detector.sv
module quad_frame_detector
  import qfd_pkg::*;
#(
  parameter int GROUP_BITS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic hit,
  output logic hit_q
);

  localparam int CNT_W = (GROUP_BITS > 1) ? $clog2(GROUP_BITS) : 1;
  localparam logic [CNT_W-1:0] POS_LAST = CNT_W'(GROUP_BITS - 1);

  qfd_state_e cur_st;
  qfd_state_e nxt_st;
  logic       hit_raw;

  qfd_next u_next (
    .cur_st (cur_st),
    .bit_in (bit_in),
    .bit_vld(bit_vld),
    .nxt_st (nxt_st),
    .hit_raw(hit_raw)
  );

  // Reset masks the Mealy pulse in the same cycle.
  assign hit = hit_raw & ~rst;

  qfd_state_reg u_reg (
    .clk    (clk),
    .rst    (rst),
    .nxt_st (nxt_st),
    .hit_raw(hit),
    .st_q   (cur_st),
    .hit_q  (hit_q)
  );

  // Independent frame position, kept only for the properties below.
  logic [CNT_W-1:0] pos_q;
  always_ff @(posedge clk) begin
    if (rst)
      pos_q <= '0;
    else if (bit_vld)
      pos_q <= (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
  end

  AST_GROUP_RESTART: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && pos_q == POS_LAST) |=> (cur_st == ST_START)); // R1

  AST_HIT_LAST_SLOT: assert property (@(posedge clk) disable iff (rst)
    hit |-> (bit_vld && pos_q == POS_LAST)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(cur_st)); // R6

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |-> !hit); // R6

  AST_DELAYED_COPY: assert property (@(posedge clk) disable iff (rst)
    hit_q == $past(hit)); // R7

endmodule

// File: tb/quad_frame_detector_tb_top.sv
`timescale 1ns/1ps
module quad_frame_detector_tb_top;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic bit_vld = 1'b0;
  logic hit;
  logic hit_q;

  int checks = 0;
  int errors = 0;
  logic prev_hit = 1'b0;

  always #2 clk = ~clk;

  quad_frame_detector dut_i (
    .clk    (clk),
    .rst    (rst),
    .bit_in (bit_in),
    .bit_vld(bit_vld),
    .hit    (hit),
    .hit_q  (hit_q)
  );

  // Entry = {vld, bit, expected hit}. Stream 0101 0010 1001 0100 with idle gaps.
  localparam int NVEC = 18;
  localparam logic [2:0] VEC [NVEC] = '{
    3'b100, 3'b110, 3'b100, 3'b010, 3'b111,
    3'b100, 3'b100, 3'b110, 3'b100,
    3'b110, 3'b000, 3'b100, 3'b100, 3'b111,
    3'b100, 3'b110, 3'b100, 3'b100
  };

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Drive one cycle away from the rising edge and check both outputs.
  task automatic step(logic r, logic v, logic b, logic exp, string req);
    @(negedge clk);
    rst = r; bit_vld = v; bit_in = b;
    #1;
    check(req, hit, exp);
    check("R7", hit_q, prev_hit);
    prev_hit = r ? 1'b0 : exp;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    check("R8 reset hit", hit, 1'b0);
    check("R8 reset hit_q", hit_q, 1'b0);
    prev_hit = 1'b0;

    // Stream table: R4 example with R6 gaps (one gap sits on a matching last bit).
    for (int i = 0; i < NVEC; i++)
      step(1'b0, VEC[i][2], VEC[i][1], VEC[i][0], VEC[i][2] ? "R4" : "R6");

    // Exhaustive frames: pulse only for 0101 and 1001, frames back to back (R1).
    for (int g = 0; g < 16; g++) begin
      for (int k = 3; k >= 0; k--) begin
        logic e;
        e = (k == 0) && (g == 5 || g == 9);
        if (k != 0)
          step(1'b0, 1'b1, g[k], 1'b0, "R3");
        else if (g[3] == g[2])
          step(1'b0, 1'b1, g[k], e, "R5");
        else
          step(1'b0, 1'b1, g[k], e, "R1 R2");
      end
    end

    // Reset collides with a matching fourth bit.
    step(1'b0, 1'b1, 1'b0, 1'b0, "R3");
    step(1'b0, 1'b1, 1'b1, 1'b0, "R3");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R3");
    step(1'b1, 1'b1, 1'b1, 1'b0, "R8 collide");
    step(1'b0, 1'b1, 1'b1, 1'b0, "R8 realign");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R8 realign");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R8 realign");
    step(1'b0, 1'b1, 1'b1, 1'b1, "R8 realign");

    // Reset mid-frame, then a dead prefix frame and a realigned match.
    step(1'b0, 1'b1, 1'b1, 1'b0, "R3");
    step(1'b1, 1'b0, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, 1'b1, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b1, 1'b0, "R5");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R6");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b1, 1'b0, "R5");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b1, 1'b1, 1'b0, "R1");
    step(1'b0, 1'b1, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b1, 1'b1, 1'b1, "R1");
    step(1'b0, 1'b0, 1'b0, 1'b0, "R7");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule